// File: doc/BRIEF.md
# Shared-Pin Legacy Interrupt Message Generator

This block turns per-function interrupt status levels into a stream of assert and deassert message events for one legacy interrupt pin shared by every function. Each function's status is gated by its own interrupt-disable bit. The gated levels are merged into a single effective pin state. Only changes of that merged state produce messages, so several functions that are active together yield one assert, and the pin deasserts only when the last active function drops.

The generator is meant for configurations with physical functions only. Legacy interrupts do not exist once virtual functions are present. Messages leave through a valid/ready interface that carries a one-bit message kind. A downstream packet builder turns each accepted event into the real message. While the output is stalled, level changes collapse: the block remembers the kind of the last message it queued and loads a new one only when the effective state differs from it.

Top module: `intx_shared_pin_gen`

## Requirements
- R1: The effective pin state is the OR over all functions of (status AND NOT disable). It is registered once, so a message can appear on `msg_valid` no earlier than the second rising edge after an input change.
- R2: When the effective state goes from low to high and the output is free, the block offers one message with `msg_kind` = 1 (assert).
- R3: When the effective state goes from high to low after an assert was queued, the block offers one message with `msg_kind` = 0 (deassert).
- R4: A deassert is never offered unless an assert was accepted since reset. After reset, a low pin produces no message.
- R5: While two or more functions are active, only one assert is sent. Dropping some, but not all, of them sends nothing.
- R6: A function's status has no effect while its disable bit is 1. Setting the disable bit of the only active function while the pin is asserted sends a deassert. Clearing it while the status is high sends an assert.
- R7: Once `msg_valid` is 1, it and `msg_kind` stay unchanged until a cycle with `msg_ready` = 1.
- R8: State changes that occur while a message waits collapse. At most one further message follows the accepted one, and only if the final effective state differs from the kind last queued.
- R9: Consecutive accepted messages always alternate in kind.
- R10: Synchronous active-high reset clears the pending message and the record of a sent assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_status | input | NUM_FUNC | Per-function interrupt status levels |
| fn_intx_off | input | NUM_FUNC | Per-function interrupt-disable bits |
| msg_valid | output | 1 | A message event is offered |
| msg_ready | input | 1 | The consumer takes the offered message |
| msg_kind | output | 1 | 1 = assert, 0 = deassert |

## Verification
The bench targets overlap between functions, where a design that follows single-function edges would send a second assert or an early deassert. It also targets disable bits toggled against high status, where an ungated design would miss the deassert or send messages from masked functions. Stalls with the pin bouncing check for collapse: a design without it would queue stale pairs, and one that drops state would lose the closing deassert. A reset taken while the pin is asserted checks that no orphan deassert follows.

// File: rtl/intx_pkg.sv
package intx_pkg;
  typedef enum logic {
    INTX_MSG_DEASSERT = 1'b0,
    INTX_MSG_ASSERT   = 1'b1
  } intx_msg_e;
endpackage

// File: rtl/intx_level_merge.sv
module intx_level_merge #(
  parameter int NUM_FUNC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FUNC-1:0] sts,
  input  logic [NUM_FUNC-1:0] dis,
  output logic                level
);
  logic [NUM_FUNC-1:0] gated;

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_gate
    assign gated[f] = sts[f] & ~dis[f];
  end

  always_ff @(posedge clk) begin
    if (rst) level <= 1'b0;
    else     level <= |gated;
  end

  // R6: with every function disabled the merged pin must read low next cycle
  p_all_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (&dis) |=> !level);
endmodule

// File: rtl/intx_msg_tracker.sv
module intx_msg_tracker
  import intx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      level,
  input  logic      slot_free,
  output logic      load,
  output intx_msg_e load_type
);
  logic queued_high_q;

  assign load      = slot_free && (level != queued_high_q);
  assign load_type = level ? INTX_MSG_ASSERT : INTX_MSG_DEASSERT;

  always_ff @(posedge clk) begin
    if (rst)       queued_high_q <= 1'b0;
    else if (load) queued_high_q <= level;
  end
endmodule

// File: rtl/intx_msg_slot.sv
module intx_msg_slot
  import intx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  intx_msg_e load_type,
  input  logic      ready,
  output logic      valid,
  output intx_msg_e kind,
  output logic      free
);
  logic seen_assert_q;

  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      kind  <= INTX_MSG_DEASSERT;
    end else if (load) begin
      valid <= 1'b1;
      kind  <= load_type;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seen_assert_q <= 1'b0;
    else if (valid && ready && kind == INTX_MSG_ASSERT) seen_assert_q <= 1'b1;
  end

  // R7: an offered message holds until taken
  p_hold_until_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(kind)));

  // R9: a message offered right after a handshake has the other kind
  p_alternate_r9: assert property (@(posedge clk) disable iff (rst)
    (valid && ready) |=> (!valid || kind != $past(kind)));

  // R4: a deassert only after an assert has been accepted
  p_deassert_after_assert_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && kind == INTX_MSG_DEASSERT) |-> seen_assert_q);
endmodule

// File: rtl/intx_shared_pin_gen.sv
module intx_shared_pin_gen
  import intx_pkg::*;
#(
  parameter int NUM_FUNC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FUNC-1:0] fn_status,
  input  logic [NUM_FUNC-1:0] fn_intx_off,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic                msg_kind
);
  logic      pin_level;
  logic      slot_free;
  logic      load;
  intx_msg_e load_type;
  intx_msg_e slot_kind;

  intx_level_merge #(.NUM_FUNC(NUM_FUNC)) u_merge (
    .clk   (clk),
    .rst   (rst),
    .sts   (fn_status),
    .dis   (fn_intx_off),
    .level (pin_level)
  );

  intx_msg_tracker u_track (
    .clk       (clk),
    .rst       (rst),
    .level     (pin_level),
    .slot_free (slot_free),
    .load      (load),
    .load_type (load_type)
  );

  intx_msg_slot u_slot (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_type (load_type),
    .ready     (msg_ready),
    .valid     (msg_valid),
    .kind      (slot_kind),
    .free      (slot_free)
  );

  assign msg_kind = slot_kind;

  // R2: a newly offered message reflects the merged level that produced it
  p_new_msg_matches_level_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> (msg_kind == $past(pin_level)));
endmodule

// File: tb/intx_shared_pin_gen_test.sv
module intx_shared_pin_gen_test;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NF-1:0] fn_status = '0;
  logic [NF-1:0] fn_intx_off = '0;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic          msg_kind;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic  exp_kind[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  intx_shared_pin_gen #(.NUM_FUNC(NF)) uut (
    .clk(clk), .rst(rst), .fn_status(fn_status), .fn_intx_off(fn_intx_off),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_msg(input logic k, input string tag);
    exp_kind.push_back(k);
    exp_tag.push_back(tag);
  endtask

  task automatic check_drained(input string tag);
    checks++;
    if (exp_kind.size() != 0) begin
      failures++;
      $display("FAIL %s: %0d expected messages missing, expected 0", tag, exp_kind.size());
      exp_kind.delete();
      exp_tag.delete();
    end
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    checks++;
    if (msg_valid !== 1'b0) begin
      failures++;
      $display("FAIL %s: msg_valid=%b expected 0", tag, msg_valid);
    end
    cyc(1);
  endtask

  // monitor: every handshake is compared against the scoreboard
  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      checks++;
      if (exp_kind.size() == 0) begin
        failures++;
        $display("FAIL unexpected message: kind=%b expected none", msg_kind);
      end else begin
        automatic logic  k = exp_kind.pop_front();
        automatic string t = exp_tag.pop_front();
        if (msg_kind !== k) begin
          failures++;
          $display("FAIL %s: msg_kind=%b expected %b", t, msg_kind, k);
        end
      end
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    // R10: reset leaves nothing pending
    check_idle("R10");
    cyc(4);
    check_idle("R4");

    // R1/R2: single function rises
    fn_status[0] = 1'b1;
    expect_msg(1'b1, "R2");
    cyc(6);
    check_drained("R2");

    // R5: overlapping functions
    fn_status[2] = 1'b1;
    cyc(4);
    fn_status[0] = 1'b0;
    cyc(4);
    check_idle("R5");
    check_drained("R5");
    fn_status[2] = 1'b0;
    expect_msg(1'b0, "R3");
    cyc(6);
    check_drained("R3");

    // R6: disable gating
    fn_intx_off[1] = 1'b1;
    fn_status[1] = 1'b1;
    cyc(5);
    check_idle("R6");
    check_drained("R6");
    fn_intx_off[1] = 1'b0;
    expect_msg(1'b1, "R6");
    cyc(6);
    fn_intx_off[1] = 1'b1;
    expect_msg(1'b0, "R6");
    cyc(6);
    check_drained("R6");
    fn_status[1] = 1'b0;
    fn_intx_off = '0;
    cyc(4);
    check_idle("R6");

    // R1/R3: one-cycle pulse gives assert then deassert
    fn_status[3] = 1'b1;
    cyc(1);
    fn_status[3] = 1'b0;
    expect_msg(1'b1, "R1");
    expect_msg(1'b0, "R3");
    cyc(8);
    check_drained("R1");

    // R4/R10: reset while asserted, then drop -> no deassert
    fn_status[0] = 1'b1;
    expect_msg(1'b1, "R2");
    cyc(6);
    check_drained("R2");
    fn_intx_off[0] = 1'b1;
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(3);
    fn_status[0] = 1'b0;
    fn_intx_off[0] = 1'b0;
    cyc(5);
    check_idle("R4");
    check_drained("R4");

    // R7/R8: stall with bouncing pin, final level low
    msg_ready = 1'b0;
    fn_status[1] = 1'b1;
    cyc(3);
    for (int i = 0; i < 3; i++) begin
      fn_status[1] = ~fn_status[1];
      @(negedge clk);
      checks++;
      if (msg_valid !== 1'b1 || msg_kind !== 1'b1) begin
        failures++;
        $display("FAIL R7: valid=%b kind=%b expected 1 1", msg_valid, msg_kind);
      end
      cyc(1);
    end
    fn_status[1] = 1'b0;
    cyc(3);
    expect_msg(1'b1, "R7");
    expect_msg(1'b0, "R8");
    msg_ready = 1'b1;
    cyc(6);
    check_drained("R8");

    // R8/R9: stall, bounce, end high -> only the assert
    msg_ready = 1'b0;
    fn_status[2] = 1'b1;
    cyc(3);
    fn_status[2] = 1'b0;
    cyc(2);
    fn_status[2] = 1'b1;
    cyc(3);
    expect_msg(1'b1, "R8");
    msg_ready = 1'b1;
    cyc(6);
    check_idle("R9");
    check_drained("R9");
    fn_status[2] = 1'b0;
    expect_msg(1'b0, "R9");
    cyc(6);
    check_drained("R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule